// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Controller

This block stands between two requesters and a single-port word memory with a one-cycle read latency. It serves plain loads and stores. It also serves indivisible read-modify-write operations: masked bit set, masked bit clear, byte test-and-set and compare-and-swap. Each request, whatever its kind, runs through the same fixed sequence: read the word, compute, write back if needed, then respond. The memory stays locked to one requester from the read until the response, so no other access can fall between the read and the write of an atomic operation.

A requester raises its valid and holds its fields steady until it sees its own response strobe. It must then drop valid before the next clock edge. When both requesters ask in the same cycle, requester 0 wins. The response carries the old value and a success flag.

Top module: `rmw_ctrl`

## Requirements
- R1: During reset and in the first idle cycle after it, `rsp_valid`, `mem_en` and `mem_we` are all low.
- R2: Opcode 3'b000 (load) returns the addressed word on `rsp_data` with `rsp_ok`=1, and issues no memory write.
- R3: Opcode 3'b001 (store) replaces only the bytes whose `req_be` bit is set (bit b covers data bits 8b+7..8b). It returns the old word with `rsp_ok`=1.
- R4: Opcode 3'b010 (bit set) writes old OR `req_wdata` and returns the old word with `rsp_ok`=1.
- R5: Opcode 3'b011 (bit clear) writes old AND NOT `req_wdata` and returns the old word with `rsp_ok`=1.
- R6: Opcode 3'b100 (test-and-set) sets byte lane `req_lane` (bits 8L+7..8L) to 0xFF. It returns that lane's original byte, zero-extended, with `rsp_ok`=1 only if that byte was not 0xFF.
- R7: Opcode 3'b101 (compare-and-swap) with the memory word equal to `req_cmp` writes `req_wdata`. It returns the old word with `rsp_ok`=1.
- R8: Compare-and-swap with the memory word different from `req_cmp` raises `mem_we` in no cycle, leaves memory unchanged, and returns the old word with `rsp_ok`=0.
- R9: When both requesters are valid in the same idle cycle, requester 0 is served first. Two test-and-sets on the same byte that is not 0xFF give the original byte to requester 0 and 0xFF with `rsp_ok`=0 to requester 1.
- R10: The grant is held from the read to the response. Any write goes to the address read two cycles earlier, so simultaneous bit-set requests on one word lose no update.
- R11: When a valid request is seen at an idle edge, the response to that requester is a single-cycle pulse on its own `rsp_valid` bit, high in the fourth cycle after the request was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 2 | Request valid, one bit per requester |
| req_op | input | 2x3 | Opcode per requester |
| req_addr | input | 2x4 | Word address per requester |
| req_wdata | input | 2x32 | Store data, bit mask or swap value |
| req_cmp | input | 2x32 | Compare value for compare-and-swap |
| req_be | input | 2x4 | Byte enables for store |
| req_lane | input | 2x2 | Byte lane for test-and-set |
| rsp_valid | output | 2 | Response strobe per requester |
| rsp_data | output | 32 | Old word, or old byte for test-and-set |
| rsp_ok | output | 1 | Success flag |
| mem_en | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 4 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_en` |

## Verification
Every opcode is driven alone against words whose contents are known. The stores use partial byte enables, which shows that unselected bytes are kept. The compare-and-swap runs once with a matching compare value and once with a differing one. A count of write strobes separates a skipped write from a write of the same value. Requests presented in the same cycle show the priority order. Test-and-set on one byte from both sides shows that only one side wins. Bit sets on different bits of one word from both sides would expose a lost update if the lock failed.

// File: rtl/rmw_pkg.sv
// Package: opcode and sequencer state encodings shared by the controller.
package rmw_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'b000,
        OP_STORE = 3'b001,
        OP_SET   = 3'b010,
        OP_CLR   = 3'b011,
        OP_TAS   = 3'b100,
        OP_CAS   = 3'b101
    } rmw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_RESP
    } rmw_state_e;
endpackage

// File: rtl/rmw_arbiter.sv
// Fixed-priority arbiter: the lowest-indexed valid requester wins.
// Assumes the sequencer only samples the result while idle (pick high).
module rmw_arbiter #(
    parameter int NREQ = 2,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_valid,
    input  logic            pick,
    output logic            gnt_valid,
    output logic [IW-1:0]   gnt_idx
);
    // Priority search from the highest index down, so index 0 ends on top.
    always_comb begin
        gnt_idx = '0;
        for (int k = NREQ - 1; k >= 0; k--) begin
            if (req_valid[k]) gnt_idx = IW'(k);
        end
    end

    assign gnt_valid = |req_valid;

    a_r9_prio_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pick && req_valid[0]) |-> (gnt_idx == '0));
endmodule

// File: rtl/rmw_alu.sv
// Operation datapath: from the old word and the captured request fields,
// forms the write-back word, the write decision, the response word and
// the success flag. Purely combinational.
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DW = 32,
    localparam int LANES = DW / 8,
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [2:0]       op,
    input  logic [DW-1:0]    old_word,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    cmp,
    input  logic [LANES-1:0] be,
    input  logic [LW-1:0]    lane,
    output logic [DW-1:0]    new_word,
    output logic             do_write,
    output logic [DW-1:0]    rsp_word,
    output logic             ok
);
    logic [DW-1:0] be_mask;
    logic [DW-1:0] lane_mask;
    logic [7:0]    lane_byte;

    // Expand byte enables into a bit mask.
    for (genvar b = 0; b < LANES; b++) begin : g_bemask
        assign be_mask[b*8 +: 8] = {8{be[b]}};
    end

    assign lane_mask = DW'(8'hFF) << (lane * 8);
    assign lane_byte = 8'(old_word >> (lane * 8));

    // Per-opcode result selection.
    always_comb begin
        new_word = old_word;
        do_write = 1'b0;
        rsp_word = old_word;
        ok       = 1'b1;
        case (op)
            OP_STORE: begin
                new_word = (old_word & ~be_mask) | (wdata & be_mask);
                do_write = 1'b1;
            end
            OP_SET: begin
                new_word = old_word | wdata;
                do_write = 1'b1;
            end
            OP_CLR: begin
                new_word = old_word & ~wdata;
                do_write = 1'b1;
            end
            OP_TAS: begin
                new_word = old_word | lane_mask;
                do_write = 1'b1;
                rsp_word = DW'(lane_byte);
                ok       = (lane_byte != 8'hFF);
            end
            OP_CAS: begin
                new_word = wdata;
                do_write = (old_word == cmp);
                ok       = (old_word == cmp);
            end
            default: begin
                new_word = old_word;
            end
        endcase
    end
endmodule

// File: rtl/rmw_seq.sv
// Lock sequencer: captures the granted request while idle, then steps
// through read, compute, write and respond. No other grant is taken
// until it is back in idle. Assumes memory returns data one cycle after
// mem_en.
module rmw_seq
    import rmw_pkg::*;
#(
    parameter int NREQ = 2,
    parameter int DW   = 32,
    parameter int AW   = 4,
    localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1,
    localparam int LANES = DW / 8,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gnt_valid,
    input  logic [IW-1:0]    gnt_idx,
    input  logic [2:0]       sel_op,
    input  logic [AW-1:0]    sel_addr,
    input  logic [DW-1:0]    sel_wdata,
    input  logic [DW-1:0]    sel_cmp,
    input  logic [LANES-1:0] sel_be,
    input  logic [LW-1:0]    sel_lane,
    input  logic [DW-1:0]    alu_new,
    input  logic             alu_wr,
    input  logic [DW-1:0]    alu_rsp,
    input  logic             alu_ok,
    output logic             pick,
    output logic [2:0]       cap_op,
    output logic [DW-1:0]    cap_wdata,
    output logic [DW-1:0]    cap_cmp,
    output logic [LANES-1:0] cap_be,
    output logic [LW-1:0]    cap_lane,
    output logic [NREQ-1:0]  rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic             rsp_ok,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata
);
    rmw_state_e      state;
    logic [IW-1:0]   owner;
    logic [AW-1:0]   cap_addr;
    logic [DW-1:0]   new_q;
    logic [DW-1:0]   rsp_q;
    logic            wr_q;
    logic            ok_q;

    // State walk and capture of the request and the computed results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            owner     <= '0;
            cap_op    <= '0;
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_cmp   <= '0;
            cap_be    <= '0;
            cap_lane  <= '0;
            new_q     <= '0;
            rsp_q     <= '0;
            wr_q      <= 1'b0;
            ok_q      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (gnt_valid) begin
                        owner     <= gnt_idx;
                        cap_op    <= sel_op;
                        cap_addr  <= sel_addr;
                        cap_wdata <= sel_wdata;
                        cap_cmp   <= sel_cmp;
                        cap_be    <= sel_be;
                        cap_lane  <= sel_lane;
                        state     <= ST_READ;
                    end
                end
                ST_READ: state <= ST_CALC;
                ST_CALC: begin
                    new_q <= alu_new;
                    wr_q  <= alu_wr;
                    rsp_q <= alu_rsp;
                    ok_q  <= alu_ok;
                    state <= ST_WRITE;
                end
                ST_WRITE: state <= ST_RESP;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign pick      = (state == ST_IDLE);
    assign mem_en    = (state == ST_READ);
    assign mem_we    = (state == ST_WRITE) && wr_q;
    assign mem_addr  = cap_addr;
    assign mem_wdata = new_q;
    assign rsp_data  = rsp_q;
    assign rsp_ok    = ok_q;

    // One response strobe per requester, raised only for the owner.
    for (genvar g = 0; g < NREQ; g++) begin : g_rsp
        assign rsp_valid[g] = (state == ST_RESP) && (owner == IW'(g));
    end

    a_r11_rsp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid != '0) |=> (rsp_valid == '0));
    a_r10_owner_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_CALC, ST_WRITE, ST_RESP}) |-> $stable(owner));
    a_r10_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_en, 2) && ($past(mem_addr, 2) == mem_addr)));
    a_r8_cas_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && cap_op == 3'(OP_CAS) && !ok_q) |-> !mem_we);
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mem_en && !mem_we && rsp_valid == '0));
endmodule

// File: rtl/rmw_ctrl.sv
// Top: atomic read-modify-write controller for two requesters in front of
// a single-port word memory. Steers the granted request's fields into the
// lock sequencer and joins the datapath. Requesters hold their fields
// until their own response strobe.
module rmw_ctrl #(
    parameter int NREQ = 2,
    parameter int DW   = 32,
    parameter int AW   = 4,
    localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1,
    localparam int LANES = DW / 8,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NREQ-1:0]            req_valid,
    input  logic [NREQ-1:0][2:0]       req_op,
    input  logic [NREQ-1:0][AW-1:0]    req_addr,
    input  logic [NREQ-1:0][DW-1:0]    req_wdata,
    input  logic [NREQ-1:0][DW-1:0]    req_cmp,
    input  logic [NREQ-1:0][LANES-1:0] req_be,
    input  logic [NREQ-1:0][LW-1:0]    req_lane,
    output logic [NREQ-1:0]            rsp_valid,
    output logic [DW-1:0]              rsp_data,
    output logic                       rsp_ok,
    output logic                       mem_en,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [DW-1:0]              mem_wdata,
    input  logic [DW-1:0]              mem_rdata
);
    logic             pick, gnt_valid;
    logic [IW-1:0]    gnt_idx;
    logic [2:0]       cap_op;
    logic [DW-1:0]    cap_wdata, cap_cmp;
    logic [LANES-1:0] cap_be;
    logic [LW-1:0]    cap_lane;
    logic [DW-1:0]    alu_new, alu_rsp;
    logic             alu_wr, alu_ok;

    rmw_arbiter #(.NREQ(NREQ)) arb_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pick(pick),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    rmw_seq #(.NREQ(NREQ), .DW(DW), .AW(AW)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
        .sel_op(req_op[gnt_idx]), .sel_addr(req_addr[gnt_idx]),
        .sel_wdata(req_wdata[gnt_idx]), .sel_cmp(req_cmp[gnt_idx]),
        .sel_be(req_be[gnt_idx]), .sel_lane(req_lane[gnt_idx]),
        .alu_new(alu_new), .alu_wr(alu_wr), .alu_rsp(alu_rsp), .alu_ok(alu_ok),
        .pick(pick), .cap_op(cap_op), .cap_wdata(cap_wdata), .cap_cmp(cap_cmp),
        .cap_be(cap_be), .cap_lane(cap_lane),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    rmw_alu #(.DW(DW)) alu_i (
        .op(cap_op), .old_word(mem_rdata), .wdata(cap_wdata), .cmp(cap_cmp),
        .be(cap_be), .lane(cap_lane),
        .new_word(alu_new), .do_write(alu_wr), .rsp_word(alu_rsp), .ok(alu_ok)
    );
endmodule

// File: tb/rmw_ctrl_tb_top.sv
// Scoreboard bench: drivers push expected responses from a reference
// model, a monitor pops and compares them as responses appear.
module rmw_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]       req_valid;
    logic [1:0][2:0]  req_op;
    logic [1:0][3:0]  req_addr;
    logic [1:0][31:0] req_wdata;
    logic [1:0][31:0] req_cmp;
    logic [1:0][3:0]  req_be;
    logic [1:0][1:0]  req_lane;
    logic [1:0]       rsp_valid;
    logic [31:0]      rsp_data;
    logic             rsp_ok;
    logic             mem_en, mem_we;
    logic [3:0]       mem_addr;
    logic [31:0]      mem_wdata, mem_rdata;

    rmw_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
        .req_be(req_be), .req_lane(req_lane), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_ok(rsp_ok), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model, one-cycle read latency.
    logic [31:0] mem [16];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) mem[k] <= '0;
            mem_rdata <= '0;
        end else begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            if (mem_en) mem_rdata <= mem[mem_addr];
        end
    end

    typedef struct {
        int          id;
        logic [31:0] data;
        logic        ok;
        string       rq;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] ref_mem [16];
    int          total = 0;
    int          bad = 0;
    int          we_cnt = 0;
    bit          done = 0;

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Reference model: computes the response and updates ref_mem.
    task automatic model(int id, logic [2:0] op, logic [3:0] a, logic [31:0] wd,
                         logic [31:0] cp, logic [3:0] be, logic [1:0] ln, string rq);
        exp_t e;
        logic [31:0] o, bm;
        logic [7:0]  by;
        o = ref_mem[a];
        e.id = id; e.data = o; e.ok = 1'b1; e.rq = rq;
        for (int b = 0; b < 4; b++) bm[b*8 +: 8] = {8{be[b]}};
        case (op)
            3'b001: ref_mem[a] = (o & ~bm) | (wd & bm);
            3'b010: ref_mem[a] = o | wd;
            3'b011: ref_mem[a] = o & ~wd;
            3'b100: begin
                by = o[ln*8 +: 8];
                e.data = {24'h0, by};
                e.ok = (by != 8'hFF);
                ref_mem[a] = o | (32'hFF << (ln * 8));
            end
            3'b101: begin
                e.ok = (o == cp);
                if (o == cp) ref_mem[a] = wd;
            end
            default: ;
        endcase
        sb.push_back(e);
    endtask

    task automatic drive(int i, logic [2:0] op, logic [3:0] a, logic [31:0] wd,
                         logic [31:0] cp, logic [3:0] be, logic [1:0] ln);
        req_op[i] = op; req_addr[i] = a; req_wdata[i] = wd;
        req_cmp[i] = cp; req_be[i] = be; req_lane[i] = ln;
        req_valid[i] = 1'b1;
    endtask

    // Single request on requester i with response timing checks (R11).
    task automatic one(int i, logic [2:0] op, logic [3:0] a, logic [31:0] wd,
                       logic [31:0] cp, logic [3:0] be, logic [1:0] ln, string rq);
        int cnt = 0;
        model(i, op, a, wd, cp, be, ln, rq);
        drive(i, op, a, wd, cp, be, ln);
        do begin
            @(negedge clk);
            cnt++;
        end while (!rsp_valid[i] && cnt < 20);
        req_valid[i] = 1'b0;
        chk("R11 latency", 32'(cnt), 32'd4);
        @(negedge clk);
        chk("R11 single pulse", 32'(rsp_valid), 32'd0);
    endtask

    // Both requesters present in the same cycle; requester 0 modelled first (R9).
    task automatic pair(logic [2:0] op0, logic [2:0] op1, logic [3:0] a,
                        logic [31:0] wd0, logic [31:0] wd1, logic [1:0] ln, string rq);
        bit d0 = 0, d1 = 0;
        int cnt = 0;
        model(0, op0, a, wd0, '0, 4'hF, ln, rq);
        model(1, op1, a, wd1, '0, 4'hF, ln, rq);
        drive(0, op0, a, wd0, '0, 4'hF, ln);
        drive(1, op1, a, wd1, '0, 4'hF, ln);
        while (!(d0 && d1) && cnt < 40) begin
            @(negedge clk);
            cnt++;
            if (rsp_valid[0]) begin d0 = 1; req_valid[0] = 1'b0; end
            if (rsp_valid[1]) begin d1 = 1; req_valid[1] = 1'b0; end
        end
        chk({rq, " both served"}, {30'd0, d1, d0}, 32'd3);
        @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each response strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid != 2'b00) begin
                if (sb.size() == 0) begin
                    chk("R11 unexpected response", 32'(rsp_valid), 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.rq, " requester"}, 32'(rsp_valid), 32'(1 << e.id));
                    chk({e.rq, " data"}, rsp_data, e.data);
                    chk({e.rq, " ok"}, {31'd0, rsp_ok}, {31'd0, e.ok});
                end
            end
            if (rst_n && mem_we) we_cnt++;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int wc;
        req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
        req_cmp = '0; req_be = '0; req_lane = '0;
        for (int k = 0; k < 16; k++) ref_mem[k] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 reset mem strobes", {30'd0, mem_en, mem_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle strobes", {29'd0, mem_en, mem_we, |rsp_valid}, 32'd0);

        // R3: full-word stores, then a partial-byte store.
        for (int k = 0; k < 8; k++)
            one(k % 2, 3'b001, 4'(k), 32'h1357_9BDF ^ (32'(k) * 32'h0101_0101), '0, 4'hF, '0, "R3 store");
        one(0, 3'b001, 4'd2, 32'hAABB_CCDD, '0, 4'b0101, '0, "R3 partial store");
        one(1, 3'b000, 4'd2, '0, '0, '0, '0, "R3 partial readback");

        // R2: load issues no write.
        wc = we_cnt;
        one(0, 3'b000, 4'd5, '0, '0, '0, '0, "R2 load");
        chk("R2 no write strobe", 32'(we_cnt - wc), 32'd0);

        // R4 / R5.
        one(1, 3'b010, 4'd3, 32'hF000_000F, '0, '0, '0, "R4 bit set");
        one(0, 3'b000, 4'd3, '0, '0, '0, '0, "R4 readback");
        one(0, 3'b011, 4'd4, 32'h0FF0_0FF0, '0, '0, '0, "R5 bit clear");
        one(1, 3'b000, 4'd4, '0, '0, '0, '0, "R5 readback");

        // R6: test-and-set, first on a clear byte then on the same byte again.
        one(0, 3'b001, 4'd8, 32'h0000_3C00, '0, 4'hF, '0, "R6 setup");
        one(0, 3'b100, 4'd8, '0, '0, '0, 2'd1, "R6 tas first");
        one(1, 3'b100, 4'd8, '0, '0, '0, 2'd1, "R6 tas again");
        one(1, 3'b100, 4'd8, '0, '0, '0, 2'd3, "R6 tas lane3");
        one(0, 3'b000, 4'd8, '0, '0, '0, '0, "R6 readback");

        // R7 / R8: compare-and-swap match then mismatch.
        one(0, 3'b101, 4'd6, 32'hDEAD_BEEF, ref_mem[6], '0, '0, "R7 cas match");
        one(1, 3'b000, 4'd6, '0, '0, '0, '0, "R7 readback");
        wc = we_cnt;
        one(1, 3'b101, 4'd7, 32'h1111_2222, ref_mem[7] ^ 32'h1, '0, '0, "R8 cas mismatch");
        chk("R8 no write strobe", 32'(we_cnt - wc), 32'd0);
        one(0, 3'b000, 4'd7, '0, '0, '0, '0, "R8 readback");

        // R9: same-cycle requests, priority and exclusive test-and-set.
        pair(3'b100, 3'b100, 4'd9, '0, '0, 2'd1, "R9 tas race");
        pair(3'b000, 3'b001, 4'd1, '0, 32'h5A5A_5A5A, '0, "R9 order");
        // R10: simultaneous bit sets on one word lose no update.
        pair(3'b010, 3'b010, 4'd10, 32'h0000_0001, 32'h0000_0100, '0, "R10 set race");
        one(0, 3'b000, 4'd10, '0, '0, '0, '0, "R10 readback");
        chk("R10 merged bits", mem[10], 32'h0000_0101);

        // Final sweep of all touched words against the reference.
        for (int k = 0; k < 11; k++)
            one(k % 2, 3'b000, 4'(k), '0, '0, '0, '0, "R2 final load");
        chk("R9 scoreboard drained", 32'(sb.size()), 32'd0);
        finish_run();
    end
endmodule